// File: doc/BRIEF.md
# Linearized Track Parameter Fitter

This block turns the full-resolution coordinates of one candidate track into fitted track parameters with a fixed affine map instead of an iterative helix fit. Each track arrives as six signed coordinates: four silicon hit positions plus the curvature and azimuth measured by the outer tracker. It carries a wedge index and a free tag. Every output is a constant row dotted with the coordinate vector, plus an offset. Three rows give curvature, azimuth and impact parameter. Three more rows give constraint residuals, and the scaled sum of their squares is the fit quality.

Each of the twelve azimuthal wedges has its own table of six rows with seven words each (six weights and one offset). A word-wide load port writes the tables. Weights are fixed point with eight fraction bits. Results are rounded half-up and clipped to 16 bits. The pipeline takes one track per clock and delivers results after a fixed delay with the tag unchanged. A track whose quality value is above a programmable limit is flagged for downstream logic, which decides what to do with it.

Top module: `track_fit_core`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` and `out_flag` are low. Reset clears every table word to zero, so a track fitted before any load returns all-zero parameters, zero quality and no flag.
- R2: Row r gives y = floor((Σ_j V[r][j]·x[j] + K[r]·256 + 128) / 256), with j = 0..5 the coordinates in `in_coord` order. Row 0 drives `out_curv`, row 1 `out_phi` and row 2 `out_d0`.
- R3: Each row value is clipped to [-32768, 32767] after rounding.
- R4: Rows 3, 4 and 5 are rounded and clipped like R2 and R3 to values c3, c4 and c5. `out_chi` = min(65535, (c3²+c4²+c5²) >> 4).
- R5: `out_flag` is high exactly when `out_chi` is strictly greater than `chi_limit`. A value equal to the limit is not flagged.
- R6: A track uses only the table of its `in_wedge`. Wedge indices 12 to 15 read an all-zero table.
- R7: When `ld_en` is high, `ld_data` is written to wedge `ld_wedge`, row `ld_row` and column `ld_col`. Columns 0..5 are the weights for coordinates 0..5 and column 6 is the offset K. A write with wedge ≥ 12, row ≥ 6 or column 7 changes nothing.
- R8: A track accepted in the same cycle as a load uses the table contents from before that load. The next track sees the new word.
- R9: One track is accepted on every cycle that `in_valid` is high. Its result appears with `out_valid` high four clock edges after the edge that accepts it, in order and with `out_tag` equal to `in_tag`.
- R10: Cycles with `in_valid` low produce cycles with `out_valid` low, and `out_flag` is low whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Track present on the input |
| in_wedge | input | 4 | Wedge index that selects the table |
| in_tag | input | 8 | Tag carried to the output |
| in_coord | input | 96 | Six signed 16-bit coordinates; coordinate j is at bits [16j+15:16j] |
| ld_en | input | 1 | Table write strobe |
| ld_wedge | input | 4 | Wedge to write |
| ld_row | input | 3 | Row to write (0..5) |
| ld_col | input | 3 | Column to write (0..5 weight, 6 offset) |
| ld_data | input | 16 | Signed word to write |
| chi_limit | input | 16 | Unsigned quality threshold |
| out_valid | output | 1 | Result present |
| out_tag | output | 8 | Tag of the result |
| out_curv | output | 16 | Fitted curvature, signed |
| out_phi | output | 16 | Fitted azimuth, signed |
| out_d0 | output | 16 | Fitted impact parameter, signed |
| out_chi | output | 16 | Fit quality, unsigned |
| out_flag | output | 1 | Quality above the limit |

## Verification
A table write and a track read can hit the same wedge word in the same cycle. The bench provokes this by changing the impact-parameter offset of wedge 0 on the edge that accepts a wedge-0 track, and then sending a second wedge-0 track on the next edge. The scoreboard predicts the first result from the table as it was before the write and the second from the table after it, so a write that bypasses to the read or arrives late shows up as a mismatch. The bench also tests saturation and the flag at the exact threshold, because rounding and clipping meet at those points.

// File: rtl/track_fit_pkg.sv
package track_fit_pkg;

    localparam int W        = 16;
    localparam int FRAC     = 8;
    localparam int N_IN     = 6;
    localparam int N_PAR    = 3;
    localparam int N_CON    = 3;
    localparam int N_ROW    = N_PAR + N_CON;
    localparam int N_TERM   = N_IN + 1;
    localparam int N_WEDGE  = 12;
    localparam int TAG_W    = 8;
    localparam int CHI_SHIFT = 4;
    localparam int PIPE_LAT = 4;

    localparam int WIW    = 4;
    localparam int RIW    = $clog2(N_ROW);
    localparam int CIW    = $clog2(N_TERM);
    localparam int ACC_W  = 2 * W + 4;
    localparam int SQ_W   = 2 * W;
    localparam int SUM_W  = SQ_W + 2;

    typedef logic [W-1:0]               word_t;
    typedef logic [N_IN-1:0][W-1:0]     vec_t;
    typedef logic [N_TERM-1:0][W-1:0]   row_t;
    typedef logic [N_ROW-1:0][N_TERM-1:0][W-1:0] table_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
    } ctl_t;

    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAX_S    = ACC_W'((1 << (W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MIN_S    = -ACC_W'(1 << (W - 1));

    function automatic word_t round_clip(input logic signed [ACC_W-1:0] acc);
        logic signed [ACC_W-1:0] r;
        r = (acc + HALF_LSB) >>> FRAC;
        if (r > MAX_S)      return word_t'(MAX_S);
        else if (r < MIN_S) return word_t'(MIN_S);
        else                return word_t'(r);
    endfunction

    function automatic word_t chi_pack(input logic [SUM_W-1:0] sum);
        logic [SUM_W-1:0] s;
        s = sum >> CHI_SHIFT;
        if (s > SUM_W'({W{1'b1}})) return {W{1'b1}};
        else                       return word_t'(s);
    endfunction

endpackage

// File: rtl/fit_coef_bank.sv
module fit_coef_bank
    import track_fit_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [WIW-1:0] wr_wedge,
    input  logic [RIW-1:0] wr_row,
    input  logic [CIW-1:0] wr_col,
    input  word_t          wr_data,
    input  logic [WIW-1:0] rd_wedge,
    output table_t         rd_table
);

    word_t mem [N_WEDGE][N_ROW][N_TERM];

    logic wr_ok;
    assign wr_ok = wr_en && (int'(wr_wedge) < N_WEDGE) &&
                   (int'(wr_row) < N_ROW) && (int'(wr_col) < N_TERM);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < N_WEDGE; w++)
                for (int r = 0; r < N_ROW; r++)
                    for (int c = 0; c < N_TERM; c++)
                        mem[w][r][c] <= '0;
        end else if (wr_ok) begin
            mem[wr_wedge][wr_row][wr_col] <= wr_data;
        end
    end

    always_comb begin
        rd_table = '0;
        if (int'(rd_wedge) < N_WEDGE) begin
            for (int r = 0; r < N_ROW; r++)
                for (int c = 0; c < N_TERM; c++)
                    rd_table[r][c] = mem[rd_wedge][r][c];
        end
    end

endmodule

// File: rtl/fit_row_unit.sv
module fit_row_unit
    import track_fit_pkg::*;
(
    input  logic  clk,
    input  vec_t  coord,
    input  row_t  coef,
    output word_t result
);

    logic signed [2*W-1:0] prod_q [N_IN];
    word_t                 off_q;
    word_t                 res_q;
    logic signed [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        for (int j = 0; j < N_IN; j++)
            prod_q[j] <= $signed(coord[j]) * $signed(coef[j]);
        off_q <= coef[N_IN];
    end

    always_comb begin
        acc = ACC_W'($signed(off_q)) <<< FRAC;
        for (int j = 0; j < N_IN; j++)
            acc = acc + ACC_W'(prod_q[j]);
    end

    always_ff @(posedge clk) begin
        res_q <= round_clip(acc);
    end

    assign result = res_q;

endmodule

// File: rtl/fit_chi_unit.sv
module fit_chi_unit
    import track_fit_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   valid_in,
    input  logic [N_CON-1:0][W-1:0] resid,
    input  word_t                  limit,
    output word_t                  chi,
    output logic                   flag
);

    logic [SQ_W-1:0]  sq_q [N_CON];
    logic             v_q;
    logic [SUM_W-1:0] sum;
    word_t            chi_q;
    word_t            chi_now;
    logic             flag_q;

    always_ff @(posedge clk) begin
        for (int k = 0; k < N_CON; k++)
            sq_q[k] <= SQ_W'($signed(resid[k]) * $signed(resid[k]));
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= valid_in;
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < N_CON; k++)
            sum = sum + SUM_W'(sq_q[k]);
    end

    assign chi_now = chi_pack(sum);

    always_ff @(posedge clk) begin
        chi_q <= chi_now;
        if (rst) flag_q <= 1'b0;
        else     flag_q <= v_q && (chi_now > limit);
    end

    assign chi  = chi_q;
    assign flag = flag_q;

endmodule

// File: rtl/track_fit_core.sv
module track_fit_core
    import track_fit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [WIW-1:0]       in_wedge,
    input  logic [TAG_W-1:0]     in_tag,
    input  logic [N_IN*W-1:0]    in_coord,
    input  logic                 ld_en,
    input  logic [WIW-1:0]       ld_wedge,
    input  logic [RIW-1:0]       ld_row,
    input  logic [CIW-1:0]       ld_col,
    input  logic [W-1:0]         ld_data,
    input  logic [W-1:0]         chi_limit,
    output logic                 out_valid,
    output logic [TAG_W-1:0]     out_tag,
    output logic [W-1:0]         out_curv,
    output logic [W-1:0]         out_phi,
    output logic [W-1:0]         out_d0,
    output logic [W-1:0]         out_chi,
    output logic                 out_flag
);

    table_t tbl;
    vec_t   coord;
    word_t  row_val [N_ROW];
    logic [N_CON-1:0][W-1:0] resid;
    logic [N_PAR-1:0][W-1:0] par_d1, par_d2;
    ctl_t   ctl [PIPE_LAT];

    assign coord = vec_t'(in_coord);

    fit_coef_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ld_en),
        .wr_wedge (ld_wedge),
        .wr_row   (ld_row),
        .wr_col   (ld_col),
        .wr_data  (ld_data),
        .rd_wedge (in_wedge),
        .rd_table (tbl)
    );

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        fit_row_unit u_row (
            .clk    (clk),
            .coord  (coord),
            .coef   (tbl[r]),
            .result (row_val[r])
        );
    end

    for (genvar k = 0; k < N_CON; k++) begin : g_res
        assign resid[k] = row_val[N_PAR + k];
    end

    fit_chi_unit u_chi (
        .clk      (clk),
        .rst      (rst),
        .valid_in (ctl[1].valid),
        .resid    (resid),
        .limit    (chi_limit),
        .chi      (out_chi),
        .flag     (out_flag)
    );

    always_ff @(posedge clk) begin
        for (int p = 0; p < N_PAR; p++) begin
            par_d1[p] <= row_val[p];
        end
        par_d2 <= par_d1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < PIPE_LAT; s++) ctl[s] <= '0;
        end else begin
            ctl[0] <= '{valid: in_valid, tag: in_tag};
            for (int s = 1; s < PIPE_LAT; s++) ctl[s] <= ctl[s-1];
        end
    end

    assign out_valid = ctl[PIPE_LAT-1].valid;
    assign out_tag   = ctl[PIPE_LAT-1].tag;
    assign out_curv  = par_d2[0];
    assign out_phi   = par_d2[1];
    assign out_d0    = par_d2[2];

endmodule

// File: rtl/track_fit_chk.sv
module track_fit_chk
    import track_fit_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [TAG_W-1:0] in_tag,
    input logic [W-1:0]     chi_limit,
    input logic             out_valid,
    input logic [TAG_W-1:0] out_tag,
    input logic [W-1:0]     out_chi,
    input logic             out_flag
);

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd1) |-> (!out_valid && !out_flag));

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    assert_tag_carry_R9: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4 && out_valid) |-> (out_tag == $past(in_tag, 4)));

    assert_flag_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
        out_flag |-> out_valid);

    assert_flag_above_limit_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 3'd0 && out_flag) |-> (out_chi > $past(chi_limit)));

endmodule

bind track_fit_core track_fit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_tag    (in_tag),
    .chi_limit (chi_limit),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_chi   (out_chi),
    .out_flag  (out_flag)
);

// File: tb/track_fit_core_tb_top.sv
`timescale 1ns/1ps
module track_fit_core_tb_top;

    localparam real HALF = 2.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_wedge = '0;
    logic [7:0]  in_tag = '0;
    logic [95:0] in_coord = '0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_wedge = '0;
    logic [2:0]  ld_row = '0;
    logic [2:0]  ld_col = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] chi_limit = '0;
    logic        out_valid;
    logic [7:0]  out_tag;
    logic [15:0] out_curv, out_phi, out_d0, out_chi;
    logic        out_flag;

    always #(HALF) clk = ~clk;

    track_fit_core dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_wedge(in_wedge),
        .in_tag(in_tag), .in_coord(in_coord), .ld_en(ld_en),
        .ld_wedge(ld_wedge), .ld_row(ld_row), .ld_col(ld_col),
        .ld_data(ld_data), .chi_limit(chi_limit), .out_valid(out_valid),
        .out_tag(out_tag), .out_curv(out_curv), .out_phi(out_phi),
        .out_d0(out_d0), .out_chi(out_chi), .out_flag(out_flag)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    curv, phi, d0, chi, tag;
        bit    flag;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   coef [12][6][7];
    bit   pend_ld = 0;
    int   pend_w, pend_r, pend_c, pend_d;
    int   lim = 0;

    function automatic int row_fit(int w, int r, int x[6]);
        longint a;
        if (w >= 12) return 0;
        a = longint'(coef[w][r][6]) * 256;
        for (int j = 0; j < 6; j++) a += longint'(coef[w][r][j]) * x[j];
        a = (a + 128) >>> 8;
        if (a > 32767)  a = 32767;
        if (a < -32768) a = -32768;
        return int'(a);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic put_track(int w, int tag, int x[6], string req);
        exp_t e;
        longint s;
        int c;
        s = 0;
        for (int r = 3; r < 6; r++) begin
            c = row_fit(w, r, x);
            s += longint'(c) * c;
        end
        s = s >>> 4;
        if (s > 65535) s = 65535;
        e.curv = row_fit(w, 0, x);
        e.phi  = row_fit(w, 1, x);
        e.d0   = row_fit(w, 2, x);
        e.chi  = int'(s);
        e.flag = (s > lim);
        e.tag  = tag;
        e.req  = req;
        exp_q.push_back(e);
        in_valid = 1'b1;
        in_wedge = 4'(w);
        in_tag   = 8'(tag);
        for (int j = 0; j < 6; j++) in_coord[j*16 +: 16] = 16'(x[j]);
    endtask

    task automatic put_load(int w, int r, int c, int d);
        ld_en = 1'b1; ld_wedge = 4'(w); ld_row = 3'(r); ld_col = 3'(c);
        ld_data = 16'(d);
        pend_ld = (w < 12) && (r < 6) && (c < 7);
        pend_w = w; pend_r = r; pend_c = c; pend_d = d;
    endtask

    task automatic tick();
        @(posedge clk);
        if (pend_ld) coef[pend_w][pend_r][pend_c] = pend_d;
        pend_ld = 0;
        @(negedge clk);
        in_valid = 1'b0;
        ld_en    = 1'b0;
    endtask

    task automatic load(int w, int r, int c, int d);
        put_load(w, r, c, d);
        tick();
    endtask

    task automatic set_limit(int v);
        lim = v;
        chi_limit = 16'(v);
    endtask

    task automatic drain();
        for (int i = 0; i < 8; i++) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R10", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(out_tag) == e.tag, e.req, "tag (R9)", out_tag, e.tag);
                check(int'($signed(out_curv)) == e.curv, e.req, "curv", $signed(out_curv), e.curv);
                check(int'($signed(out_phi)) == e.phi, e.req, "phi", $signed(out_phi), e.phi);
                check(int'($signed(out_d0)) == e.d0, e.req, "d0", $signed(out_d0), e.d0);
                check(int'(out_chi) == e.chi, e.req, "chi (R4)", out_chi, e.chi);
                check(out_flag == e.flag, e.req, "flag (R5)", out_flag, e.flag);
            end
        end
    end

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int x[6];
        int lat;
        for (int w = 0; w < 12; w++)
            for (int r = 0; r < 6; r++)
                for (int c = 0; c < 7; c++) coef[w][r][c] = 0;

        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_flag == 0, "R1", "outputs in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);

        // R1: table cleared by reset
        x = '{1000, -2000, 300, 44, 5000, -600};
        put_track(0, 1, x, "R1"); tick(); drain();

        // R2 program wedge 0
        load(0, 0, 4, 256);
        load(0, 1, 5, 256);
        load(0, 1, 6, 10);
        load(0, 2, 0, 128);
        load(0, 2, 1, -128);
        load(0, 3, 0, 256);
        load(0, 4, 1, 256);
        load(0, 5, 2, 256);
        set_limit(712);
        // d0 = 31.5 rounds up to 32; chi = 712 equals the limit: no flag
        x = '{100, 37, 5, 0, -1234, 777};
        put_track(0, 2, x, "R2"); tick();
        x = '{100, 38, 5, 0, 17, -9};
        put_track(0, 3, x, "R2"); tick();
        drain();
        set_limit(711);
        x = '{100, 37, 5, 0, 1, 2};
        put_track(0, 4, x, "R5"); tick(); drain();

        // R3 saturation and R4 chi clip
        load(0, 0, 3, 256);
        x = '{32767, 32767, 32767, 1000, 32767, 0};
        put_track(0, 5, x, "R3"); tick();
        x = '{-32768, -32768, 0, -5, -32768, 0};
        put_track(0, 6, x, "R3"); tick();
        drain();

        // R6 wedge selection, back-to-back stream (R9)
        load(7, 0, 4, -512);
        load(7, 3, 5, 64);
        for (int i = 0; i < 6; i++) begin
            x = '{i*10, -i, 3, 7, 100 + i, 40 * i};
            put_track((i % 2 == 0) ? 0 : 7, 16 + i, x, "R6");
            tick();
        end
        x = '{10, 20, 30, 40, 50, 60};
        put_track(13, 30, x, "R6"); tick();
        drain();

        // R7 out-of-range writes are dropped
        load(12, 0, 4, 256);
        load(0, 6, 0, 999);
        load(0, 2, 7, 999);
        x = '{10, 20, 30, 40, 50, 60};
        put_track(12, 31, x, "R7"); tick();
        put_track(0, 32, x, "R7"); tick();
        drain();

        // R8 load and track on the same edge
        x = '{200, 100, 1, 2, 3, 4};
        put_track(0, 40, x, "R8");
        put_load(0, 2, 6, 500);
        tick();
        put_track(0, 41, x, "R8"); tick();
        drain();

        // R9 latency and R10 bubbles
        x = '{1, 2, 3, 4, 5, 6};
        put_track(7, 50, x, "R9");
        lat = 0;
        @(posedge clk);
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            in_valid = 1'b0;
            lat++;
        end
        check(lat == 4, "R9", "latency in cycles", lat, 4);
        drain();
        check(out_valid == 0 && out_flag == 0, "R10", "idle outputs", out_valid, 0);
        check(exp_q.size() == 0, "R10", "results outstanding", exp_q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule